// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This unit freezes a copy of the running calendar into a pair of holding registers when something happens. Two things can start a capture. A falling edge on an asynchronous, active-low event pin can start one, and software can start one by writing a request to the status register. The live time word and date word come from a calendar counter that runs in the same clock domain. A capture sets a sticky event flag and sends a one-cycle interrupt pulse. After that the unit ignores every further request until software clears the flag.

When captures are disabled, the time and date holding registers work as plain read/write storage. These registers are cleared only by the power-on reset. The ordinary system reset clears the control state and the flag, but the captured or stored values survive it.

Top module: `tstamp_capture`

## Requirements
- R1: The event pin passes through a two-flop synchronizer. If the pin is first sampled low at rising edge k, and captures are enabled with the flag clear, then at edge k+2 the holding registers load the time and date words present at edge k+2, and the flag reads 1 from then on.
- R2: While the capture enable is low, pulses on the event pin leave the flag at 0 and the holding registers unchanged.
- R3: The interrupt output is high for exactly one cycle, and that cycle is the first one in which the flag reads 1. This applies to both hardware and software captures.
- R4: While the flag is set, no capture can happen. An event pin pulse leaves the holding registers unchanged, and writing 1 to the flag bit leaves the flag at 1 and the holding registers unchanged.
- R5: Writing 0 to status bit 0 clears the flag. The next event then captures again.
- R6: A write of 1 to status bit 0, made with the enable set and the flag clear, starts a software capture. The flag still reads 0 in the two cycles after the write edge and reads 1 after the second edge that follows it. The holding registers receive the time and date present at the first edge after the write.
- R7: While the enable is low, writes to address 1 (time) and address 2 (date) store the data, and the stored value reads back. While the enable is high, those writes are ignored.
- R8: The system reset clears the flag and the interrupt but keeps the holding registers. The power-on reset clears everything, including both holding registers, to 0.
- R9: The register map has four addresses. Address 0 holds the flag in bit 0, with all other bits reading 0. Address 1 reads the held time, address 2 reads the held date, and address 3 reads 0.
- R10: A pin held low for many cycles produces a single capture. The pin's return to high produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous system reset, active high |
| por_i | input | 1 | Synchronous power-on reset, active high |
| evt_n_i | input | 1 | Asynchronous event pin, active low |
| cap_en_i | input | 1 | Capture enable |
| time_i | input | 32 | Live time word |
| date_i | input | 32 | Live date word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a capture strobe loads exactly the live words;
- the holding registers stay frozen while the flag is set and while the enable is high without a capture;
- the interrupt only pulses on the rising of the flag;
- the software request follows its two-cycle latency;
- the system reset leaves the stored words untouched.

Only the bench scenarios can show the following:
- the full pin-to-flag latency through the synchronizer;
- that a long low pulse yields one capture;
- that clearing the flag re-arms the unit;
- that storage writes read back through the register map.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

    localparam int TIME_W   = 32;
    localparam int DATE_W   = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int FLAG_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT  = 2'd0,
        REG_TIME  = 2'd1,
        REG_DATE  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_SWCAP,
        CS_SWFIN,
        CS_HELD
    } cap_state_e;

    typedef struct packed {
        logic [TIME_W-1:0] tm;
        logic [DATE_W-1:0] dt;
    } stamp_t;

    function automatic logic [DATA_W-1:0] pad_time(input logic [TIME_W-1:0] v);
        return DATA_W'(v);
    endfunction

    function automatic logic [DATA_W-1:0] pad_date(input logic [DATE_W-1:0] v);
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/tstamp_sync.sv
module tstamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_n_i,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin_n_i};
        end
    end

    // falling edge of the synchronized level: previous high, current low
    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R10: one edge yields one single-cycle pulse
    assert_single_fall_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
    import tstamp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic hw_fall_i,
    input  logic cap_en_i,
    input  logic stat_wr_i,
    input  logic stat_bit_i,
    output logic flag_o,
    output logic irq_o,
    output logic strobe_o
);
    cap_state_e st_q, st_d;
    logic       irq_q;
    logic       hw_go, sw_go, clr_go;

    always_comb begin
        hw_go  = (st_q == CS_IDLE) && cap_en_i && hw_fall_i;
        sw_go  = (st_q == CS_IDLE) && cap_en_i && stat_wr_i && stat_bit_i && !hw_fall_i;
        clr_go = (st_q == CS_HELD) && stat_wr_i && !stat_bit_i;
        st_d   = st_q;
        unique case (st_q)
            CS_IDLE: begin
                if (hw_go) begin
                    st_d = CS_HELD;
                end else if (sw_go) begin
                    st_d = CS_SWCAP;
                end
            end
            CS_SWCAP: st_d = CS_SWFIN;
            CS_SWFIN: st_d = CS_HELD;
            CS_HELD: begin
                if (clr_go) begin
                    st_d = CS_IDLE;
                end
            end
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= CS_IDLE;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= (st_d == CS_HELD) && (st_q != CS_HELD);
        end
    end

    assign flag_o   = (st_q == CS_HELD);
    assign irq_o    = irq_q;
    assign strobe_o = !rst_i && (hw_go || (st_q == CS_SWCAP));

    // R3: the interrupt marks the first cycle of a set flag and lasts one cycle
    assert_irq_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flag_o && !$past(flag_o)));
    assert_irq_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o);

    // R4: the flag holds until a clearing write
    assert_flag_lock_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !(stat_wr_i && !stat_bit_i)) |=> flag_o);

    // R2: no capture without the enable
    assert_no_enable_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!flag_o && st_q == CS_IDLE && !cap_en_i) |=> !flag_o);

    // R6: software request sets the flag two edges after the write edge
    assert_sw_latency_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_go |=> !flag_o ##1 !flag_o ##1 flag_o);

endmodule

// File: rtl/tstamp_hold.sv
module tstamp_hold
    import tstamp_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              strobe_i,
    input  stamp_t            live_i,
    input  logic              wr_time_i,
    input  logic              wr_date_i,
    input  logic [DATA_W-1:0] wdata_i,
    output stamp_t            held_o
);
    stamp_t held_q;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            held_q <= '0;
        end else if (strobe_i) begin
            held_q <= live_i;
        end else begin
            if (wr_time_i) begin
                held_q.tm <= wdata_i[TIME_W-1:0];
            end
            if (wr_date_i) begin
                held_q.dt <= wdata_i[DATE_W-1:0];
            end
        end
    end

    assign held_o = held_q;

    // R1: a capture strobe copies exactly the live words
    assert_capture_copy_R1: assert property (@(posedge clk_i) disable iff (por_i)
        strobe_i |=> (held_o == $past(live_i)));

    // R7: a storage write lands when no capture competes
    assert_store_time_R7: assert property (@(posedge clk_i) disable iff (por_i)
        (wr_time_i && !strobe_i) |=> (held_o.tm == $past(wdata_i[TIME_W-1:0])));

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
    import tstamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic              evt_n_i,
    input  logic              cap_en_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic [DATE_W-1:0] date_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic     sys_rst;
    logic     evt_fall;
    logic     flag;
    logic     strobe;
    logic     stat_wr, wr_time, wr_date;
    reg_sel_e sel;
    stamp_t   live, held;

    assign sys_rst = rst_i | por_i;
    assign sel     = reg_sel_e'(reg_addr_i);
    assign live    = '{tm: time_i, dt: date_i};

    assign stat_wr = reg_wr_i && !sys_rst && (sel == REG_STAT);
    assign wr_time = reg_wr_i && !sys_rst && !cap_en_i && (sel == REG_TIME);
    assign wr_date = reg_wr_i && !sys_rst && !cap_en_i && (sel == REG_DATE);

    tstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (sys_rst),
        .pin_n_i(evt_n_i),
        .fall_o (evt_fall)
    );

    tstamp_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (sys_rst),
        .hw_fall_i (evt_fall),
        .cap_en_i  (cap_en_i),
        .stat_wr_i (stat_wr),
        .stat_bit_i(reg_wdata_i[FLAG_BIT]),
        .flag_o    (flag),
        .irq_o     (irq_o),
        .strobe_o  (strobe)
    );

    tstamp_hold u_hold (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .strobe_i (strobe),
        .live_i   (live),
        .wr_time_i(wr_time),
        .wr_date_i(wr_date),
        .wdata_i  (reg_wdata_i),
        .held_o   (held)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            REG_STAT:  reg_rdata_o[FLAG_BIT] = flag;
            REG_TIME:  reg_rdata_o = pad_time(held.tm);
            REG_DATE:  reg_rdata_o = pad_date(held.dt);
            default:   reg_rdata_o = '0;
        endcase
    end

    // R8: the system reset alone never disturbs the holding registers
    assert_keep_on_reset_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_i && !por_i) |=> $stable(held));

    // R4: with the flag set the holding registers are frozen
    assert_frozen_flag_R4: assert property (@(posedge clk_i) disable iff (sys_rst)
        (flag && cap_en_i) |=> $stable(held));

    // R7: with the enable high only a capture may change the holding registers
    assert_no_store_enabled_R7: assert property (@(posedge clk_i) disable iff (por_i)
        (cap_en_i && !strobe) |=> $stable(held));

endmodule

// File: tb/tstamp_capture_test.sv
module tstamp_capture_test;
    import tstamp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              por = 1'b1;
    logic              evt_n = 1'b1;
    logic              cap_en = 1'b0;
    logic [TIME_W-1:0] time_w = '0;
    logic [DATE_W-1:0] date_w = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    bit done   = 0;

    logic [DATA_W-1:0] exp_tm, exp_dt;

    int    q_kind[$];
    logic [DATA_W-1:0] q_exp[$];
    string q_tag[$];

    tstamp_capture uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .por_i      (por),
        .evt_n_i    (evt_n),
        .cap_en_i   (cap_en),
        .time_i     (time_w),
        .date_i     (date_w),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_o      (irq)
    );

    always #5 clk = ~clk;

    // live calendar words change at every falling edge
    always @(negedge clk) begin
        tick++;
        time_w = 32'h1000_0000 + tick;
        date_w = 32'h2000_0000 + tick * 3;
    end

    // monitor: pop every expected item and compare against the ports
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int k;
            logic [DATA_W-1:0] e, a;
            string t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = (k == 0) ? reg_rdata : {{(DATA_W-1){1'b0}}, irq};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic exp_irq(input logic v, input string tag);
        q_kind.push_back(1);
        q_exp.push_back({{(DATA_W-1){1'b0}}, v});
        q_tag.push_back(tag);
    endtask

    task automatic check_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v,
                             input string tag);
        reg_addr = a;
        q_kind.push_back(0);
        q_exp.push_back(v);
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // event pulse; when a capture is expected, check latency, values and irq
    task automatic hw_event(input bit expect_cap, input string tag);
        @(posedge clk); #1 evt_n = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        if (expect_cap) begin
            check_reg(REG_STAT, 32'd0, {tag, " flag before edge k+2"});
            exp_tm = time_w;
            exp_dt = date_w;
            @(posedge clk); #1;
            exp_irq(1'b1, "R3 irq on flag set");
            check_reg(REG_STAT, 32'd1, {tag, " flag at edge k+2"});
            @(posedge clk); #1;
            exp_irq(1'b0, "R3 irq single cycle");
            check_reg(REG_STAT, 32'd1, "R10 flag held while pin low");
        end
        idle(4);
        evt_n = 1'b1;
        idle(5);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        idle(4);
        por = 1'b0; rst = 1'b0;
        idle(1);

        // reset state and register map (R8, R9)
        exp_irq(1'b0, "R8 irq after reset");
        check_reg(REG_STAT, 32'd0, "R8 flag after power-on");
        check_reg(REG_TIME, 32'd0, "R8 time after power-on");
        check_reg(REG_DATE, 32'd0, "R8 date after power-on");
        check_reg(REG_SPARE, 32'd0, "R9 spare address");

        // storage mode (R7)
        reg_write(REG_TIME, 32'hDEAD_BEEF);
        reg_write(REG_DATE, 32'h1234_5678);
        check_reg(REG_TIME, 32'hDEAD_BEEF, "R7 stored time");
        check_reg(REG_DATE, 32'h1234_5678, "R7 stored date");

        // pin pulse while disabled (R2)
        hw_event(1'b0, "R2");
        check_reg(REG_STAT, 32'd0, "R2 flag stays clear");
        check_reg(REG_TIME, 32'hDEAD_BEEF, "R2 time untouched");

        // writes ignored while enabled (R7)
        cap_en = 1'b1;
        reg_write(REG_TIME, 32'h0000_0001);
        check_reg(REG_TIME, 32'hDEAD_BEEF, "R7 enabled write ignored");
        check_reg(REG_STAT, 32'd0, "R7 no flag from storage write");

        // hardware capture (R1, R3, R10)
        hw_event(1'b1, "R1");
        check_reg(REG_TIME, exp_tm, "R1 captured time");
        check_reg(REG_DATE, exp_dt, "R1 captured date");
        exp_irq(1'b0, "R10 no irq on release");
        check_reg(REG_STAT, 32'h1, "R9 status reads flag only");

        // lockout (R4)
        hw_event(1'b0, "R4");
        check_reg(REG_TIME, exp_tm, "R4 time frozen on event");
        reg_write(REG_STAT, 32'h1);
        exp_irq(1'b0, "R4 no irq from blocked request");
        check_reg(REG_STAT, 32'd1, "R4 flag stays set");
        idle(3);
        check_reg(REG_TIME, exp_tm, "R4 time frozen on request");
        check_reg(REG_DATE, exp_dt, "R4 date frozen on request");

        // clear and re-arm (R5)
        reg_write(REG_STAT, 32'h0);
        check_reg(REG_STAT, 32'd0, "R5 flag cleared");
        hw_event(1'b1, "R5");
        check_reg(REG_TIME, exp_tm, "R5 re-armed time");
        check_reg(REG_DATE, exp_dt, "R5 re-armed date");

        // software capture (R6)
        reg_write(REG_STAT, 32'h0);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = REG_STAT; reg_wdata = 32'h1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        check_reg(REG_STAT, 32'd0, "R6 flag clear after write edge");
        exp_tm = time_w;
        exp_dt = date_w;
        @(posedge clk); #1;
        check_reg(REG_STAT, 32'd0, "R6 flag clear one edge later");
        @(posedge clk); #1;
        exp_irq(1'b1, "R3 irq on software capture");
        check_reg(REG_STAT, 32'd1, "R6 flag set two edges later");
        check_reg(REG_TIME, exp_tm, "R6 software time");
        check_reg(REG_DATE, exp_dt, "R6 software date");

        // system reset keeps data, power-on clears it (R8)
        @(posedge clk); #1 rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        check_reg(REG_STAT, 32'd0, "R8 flag cleared by reset");
        check_reg(REG_TIME, exp_tm, "R8 time kept through reset");
        check_reg(REG_DATE, exp_dt, "R8 date kept through reset");
        @(posedge clk); #1 por = 1'b1;
        idle(2);
        por = 1'b0;
        idle(1);
        check_reg(REG_TIME, 32'd0, "R8 time cleared by power-on");
        check_reg(REG_DATE, 32'd0, "R8 date cleared by power-on");

        idle(2);
        done = 1;
        report();
    end

endmodule